// File: doc/BRIEF.md
# Palette Lookup With Colour Expansion

This block holds a colour palette for a display pipeline. The register side writes 32-bit words. Each word carries two packed 16-bit palette entries. On every word write the block expands both entries at once into 24-bit colours and stores them in a 256-entry lookup. The register side can also read back the raw 32-bit word it stored.

On the pixel side, an 8-bit palette index comes in with a request strobe. One clock later the block returns the expanded 24-bit colour with a valid flag. Address decoding happens upstream, so the block only sees a word index, a write strobe and the data.

Within a packed entry, the three 5-bit colour fields are widened to 8 bits by appending three zero bits. The top bit of each entry is an intensity flag, and the block drops it.

Top module: `palette_lut`

## Requirements
- R1: `rawRdData` is the stored 32-bit word selected by `rawRdAddr`, with no clock delay. A word written at a clock edge is visible there from that edge onward.
- R2: A write of word n stores bits [15:0] as palette entry 2n and bits [31:16] as palette entry 2n+1. Both entries are updated by the single write.
- R3: In a 16-bit entry, bits [4:0] become output colour bits [7:0], bits [9:5] become bits [15:8], and bits [14:10] become bits [23:16].
- R4: Each 5-bit field is widened by a left shift of 3. The three low bits of every output byte are zero.
- R5: Bit 15 of an entry (the intensity flag) has no effect on the colour returned for that entry.
- R6: A pixel request (`pixReq` high with `pixIdx`) returns `pixColor` with `pixValid` high on the next cycle. `pixValid` is low in any cycle that follows a cycle without a request.
- R7: When a write and a pixel read of the same entry happen in the same cycle, the read returns the entry's value from before the write.
- R8: After reset, all raw words and all expanded entries read as zero, and `pixValid` and `pixColor` are zero.
- R9: `pixColor` holds its last value in any cycle that follows a cycle without a pixel request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Raw palette word write strobe |
| wrAddr | input | 7 | Raw word index to write |
| wrData | input | 32 | Raw word (two packed entries) |
| rawRdAddr | input | 7 | Raw word index for readback |
| rawRdData | output | 32 | Raw word readback |
| pixReq | input | 1 | Pixel lookup request |
| pixIdx | input | 8 | Palette index for lookup |
| pixValid | output | 1 | Lookup result valid |
| pixColor | output | 24 | Expanded colour |

## Verification
The assertions check four properties on every cycle:
- the one-cycle relation between `pixReq` and `pixValid`;
- the zero low bits of every returned colour byte;
- holding of `pixColor` when no request was made;
- raw readback of the word written in the previous cycle.

Other properties need a reference value that only the bench's directed scenarios can supply:
- which half of a word lands in which entry;
- the field ordering within an entry;
- the intensity bit having no effect;
- the old-value result on a write and read of the same entry;
- the all-zero state after reset.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int unsigned WORD_COUNT = 128;
  localparam int unsigned WORD_AW    = $clog2(WORD_COUNT);
  localparam int unsigned IDX_W      = WORD_AW + 1;
  localparam int unsigned RAW_W      = 32;
  localparam int unsigned ENTRY_W    = RAW_W / 2;
  localparam int unsigned FIELD_W    = 5;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned COLOR_W    = 3 * BYTE_W;

  typedef struct packed {
    logic               wrFire;
    logic [WORD_AW-1:0] wrWord;
    logic               rdFire;
    logic [IDX_W-1:0]   rdIdx;
  } palStrobes_t;
endpackage

// File: rtl/colour_expand.sv
module colour_expand #(
  parameter int unsigned FIELD_W = 5,
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned FIELDS  = 3
) (
  input  logic [FIELDS*FIELD_W-1:0] entryBits,
  output logic [FIELDS*BYTE_W-1:0]  rgbOut
);
  localparam int unsigned PAD_W = BYTE_W - FIELD_W;

  for (genvar k = 0; k < FIELDS; k++) begin : g_field
    assign rgbOut[k*BYTE_W +: BYTE_W] = {entryBits[k*FIELD_W +: FIELD_W], {PAD_W{1'b0}}};
  end
endmodule

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [WORD_AW-1:0] wrAddr,
  input  logic               pixReq,
  input  logic [IDX_W-1:0]   pixIdx,
  output palStrobes_t        strobes,
  output logic               pixValid
);
  always_comb begin
    strobes.wrFire = wrEn;
    strobes.wrWord = wrAddr;
    strobes.rdFire = pixReq;
    strobes.rdIdx  = pixIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pixValid <= 1'b0;
    else       pixValid <= pixReq;
  end
endmodule

// File: rtl/palette_store.sv
module palette_store
  import palette_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  palStrobes_t        strobes,
  input  logic [RAW_W-1:0]   wrData,
  input  logic [WORD_AW-1:0] rawRdAddr,
  output logic [RAW_W-1:0]   rawRdData,
  output logic [COLOR_W-1:0] pixColor
);
  localparam int unsigned ENTRY_COUNT = 2 * WORD_COUNT;
  localparam int unsigned COLOR_BITS  = 3 * FIELD_W;

  logic [RAW_W-1:0]   rawMem [WORD_COUNT];
  logic [COLOR_W-1:0] lutMem [ENTRY_COUNT];
  logic [COLOR_W-1:0] expanded [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    colour_expand #(
      .FIELD_W(FIELD_W),
      .BYTE_W (BYTE_W),
      .FIELDS (3)
    ) u_expand (
      .entryBits(wrData[h*ENTRY_W +: COLOR_BITS]),
      .rgbOut   (expanded[h])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORD_COUNT; i++) rawMem[i] <= '0;
    end else if (strobes.wrFire) begin
      rawMem[strobes.wrWord] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRY_COUNT; i++) lutMem[i] <= '0;
    end else if (strobes.wrFire) begin
      lutMem[{strobes.wrWord, 1'b0}] <= expanded[0];
      lutMem[{strobes.wrWord, 1'b1}] <= expanded[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pixColor <= '0;
    else if (strobes.rdFire) pixColor <= lutMem[strobes.rdIdx];
  end

  assign rawRdData = rawMem[rawRdAddr];
endmodule

// File: rtl/palette_lut.sv
module palette_lut
  import palette_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [WORD_AW-1:0] wrAddr,
  input  logic [RAW_W-1:0]   wrData,
  input  logic [WORD_AW-1:0] rawRdAddr,
  output logic [RAW_W-1:0]   rawRdData,
  input  logic               pixReq,
  input  logic [IDX_W-1:0]   pixIdx,
  output logic               pixValid,
  output logic [COLOR_W-1:0] pixColor
);
  palStrobes_t strobes;

  palette_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .pixReq  (pixReq),
    .pixIdx  (pixIdx),
    .strobes (strobes),
    .pixValid(pixValid)
  );

  palette_store u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (wrData),
    .rawRdAddr(rawRdAddr),
    .rawRdData(rawRdData),
    .pixColor (pixColor)
  );
endmodule

// File: rtl/palette_lut_checker.sv
module palette_lut_checker
  import palette_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [WORD_AW-1:0] wrAddr,
  input logic [RAW_W-1:0]   wrData,
  input logic [WORD_AW-1:0] rawRdAddr,
  input logic [RAW_W-1:0]   rawRdData,
  input logic               pixReq,
  input logic [IDX_W-1:0]   pixIdx,
  input logic               pixValid,
  input logic [COLOR_W-1:0] pixColor
);
  // R6: a request yields a valid result on the next cycle
  a_r6_valid_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    pixReq |=> pixValid);

  // R6: no request means no valid result on the next cycle
  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !pixReq |=> !pixValid);

  // R4: widened bytes carry zero low bits
  a_r4_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |-> ((pixColor & 24'h070707) == 24'h0));

  // R9: colour holds when the previous cycle had no request
  a_r9_colour_holds: assert property (@(posedge clk) disable iff (!rstN)
    !pixReq |=> $stable(pixColor));

  // R1: the word just written is visible on readback
  a_r1_raw_readback: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wrEn) && (rawRdAddr == $past(wrAddr)))
      |-> (rawRdData == $past(wrData)));
endmodule

bind palette_lut palette_lut_checker u_checker (.*);

// File: tb/tb_palette_lut.sv
`timescale 1ns/1ps
module tb_palette_lut;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [6:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [6:0]  rawRdAddr = '0;
  logic [31:0] rawRdData;
  logic        pixReq = 1'b0;
  logic [7:0]  pixIdx = '0;
  logic        pixValid;
  logic [23:0] pixColor;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  palette_lut dut (.*);

  function automatic logic [23:0] expand(input logic [15:0] e);
    return {e[14:10], 3'b000, e[9:5], 3'b000, e[4:0], 3'b000};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeWord(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic lookup(input logic [7:0] idx, output logic [23:0] c, output logic v);
    @(negedge clk);
    pixReq = 1'b1; pixIdx = idx;
    @(negedge clk);
    pixReq = 1'b0;
    c = pixColor; v = pixValid;
  endtask

  task automatic t_reset;
    logic [23:0] c; logic v;
    @(negedge clk);
    check("R8 pixValid", {31'b0, pixValid}, 32'h0);
    check("R8 pixColor", {8'b0, pixColor}, 32'h0);
    rawRdAddr = 7'd5; #1;
    check("R8 raw word", rawRdData, 32'h0);
    lookup(8'd11, c, v);
    check("R8 entry zero", {8'b0, c}, 32'h0);
    check("R6 valid", {31'b0, v}, 32'h1);
  endtask

  task automatic t_halves;
    logic [23:0] c; logic v;
    writeWord(7'd3, 32'h2A5F_1234);
    lookup(8'd6, c, v);
    check("R2 low half entry 6", {8'b0, c}, {8'b0, expand(16'h1234)});
    lookup(8'd7, c, v);
    check("R2 high half entry 7", {8'b0, c}, {8'b0, expand(16'h2A5F)});
    @(negedge clk);
    check("R6 valid drops", {31'b0, pixValid}, 32'h0);
    check("R9 colour held", {8'b0, pixColor}, {8'b0, expand(16'h2A5F)});
  endtask

  task automatic t_fields;
    logic [23:0] c; logic v;
    writeWord(7'd10, {16'h03E0, 16'h001F});
    lookup(8'd20, c, v);
    check("R3 first field to low byte", {8'b0, c}, 32'h0000F8);
    lookup(8'd21, c, v);
    check("R3 green to middle byte", {8'b0, c}, 32'h00F800);
    writeWord(7'd10, {16'h0421, 16'h7C00});
    lookup(8'd20, c, v);
    check("R3 third field to top byte", {8'b0, c}, 32'hF80000);
    lookup(8'd21, c, v);
    check("R4 value one widened", {8'b0, c}, 32'h080808);
  endtask

  task automatic t_intensity;
    logic [23:0] c; logic v;
    writeWord(7'd20, {16'hFFFF, 16'h8000});
    lookup(8'd40, c, v);
    check("R5 intensity only", {8'b0, c}, 32'h0);
    lookup(8'd41, c, v);
    check("R5 intensity with full colour", {8'b0, c}, 32'hF8F8F8);
  endtask

  task automatic t_raw;
    writeWord(7'd127, 32'hDEAD_BEEF);
    rawRdAddr = 7'd127; #1;
    check("R1 raw readback", rawRdData, 32'hDEADBEEF);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 7'd127; wrData = 32'h1357_2468;
    @(posedge clk); #1;
    check("R1 raw visible after edge", rawRdData, 32'h13572468);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic t_boundary;
    logic [23:0] c; logic v;
    lookup(8'd255, c, v);
    check("R2 entry 255 from word 127 high", {8'b0, c}, {8'b0, expand(16'h1357)});
    writeWord(7'd0, 32'h7FFF_0C63);
    lookup(8'd0, c, v);
    check("R2 entry 0", {8'b0, c}, {8'b0, expand(16'h0C63)});
  endtask

  task automatic t_collision;
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 7'd40; wrData = 32'h0000_7FFF;
    pixReq = 1'b1; pixIdx = 8'd80;
    @(negedge clk);
    wrEn = 1'b0;
    check("R7 old value on collision", {8'b0, pixColor}, 32'h0);
    @(negedge clk);
    pixReq = 1'b0;
    check("R7 new value next cycle", {8'b0, pixColor}, 32'hF8F8F8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_halves();
    t_fields();
    t_intensity();
    t_raw();
    t_boundary();
    t_collision();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule